// File: doc/BRIEF.md
# I2S Slot Width Halving Converter

This block sits between an I2S source that spends 64 bit-clock periods on each channel and a sink that expects the usual 32. Everything runs on a single master clock at 256 times the sample rate. The incoming bit clock, at half the master rate, and the word-select are passed through two-flop synchronisers. Their edges are found by comparing successive synchronised values. Each word-select transition opens a new channel slot and empties a 31-bit holding buffer. The first 31 data bits after the one-bit I2S delay are written into the buffer at the input bit rate. Later bits of the input slot are dropped.

An emitter state machine regenerates a bit clock at one quarter of the master rate and drains the buffer MSB first, one bit per output period. Data changes only while the regenerated clock is low, so the sink samples it on the rising edge. The output word-select moves at the start of every output slot and keeps the I2S one-bit delay. As a result, the sink sees each sample unchanged, zero-padded, in a 32-period slot on the correct channel.

The capture machine has three states:
- CAP_WAIT: no slot has opened yet.
- CAP_FILL: storing bits.
- CAP_DROP: discarding the rest of the slot.

It moves from WAIT to FILL on a word-select edge, from FILL to DROP after the 31st stored bit, and from any state back to FILL on the next word-select edge.

The emitter machine also has three states:
- EMIT_IDLE: outputs held low until the first slot.
- EMIT_LOW: two master cycles with the clock low, data launched on entry.
- EMIT_HIGH: two master cycles with the clock high.

It moves from LOW to HIGH after the low half, and from HIGH to LOW after the high half, launching the next bit. Any slot start forces it into LOW at position 0.

Top module: `i2s_slot_halver`

## Requirements
- R1: After reset, bclk_out, ws_out and sd_out are 0. bclk_out stays 0 until the first word-select transition, which needs at least one earlier input bit-clock rise as a reference.
- R2: While running, bclk_out rises after at least two low master cycles. Inside a slot, successive rises of bclk_out are exactly 4 master cycles apart.
- R3: When input slots last 64 input bit periods, every output slot holds exactly 32 rising edges of bclk_out. No slot ever holds more than 32.
- R4: ws_out and sd_out change only in cycles where bclk_out is low, so both are stable across each high phase.
- R5: Output position k is the k-th rising edge of bclk_out after a ws_out change, counted from 0. Input bit k of a slot appears at output position k for k = 1..31, with the MSB at position 1. ws_out = 0 marks the left channel and 1 the right, and it follows the input word-select level of that slot. A 24-bit sample therefore reads back unchanged at positions 1..24, including samples with only 18 significant bits.
- R6: Output position 0 is always 0. Input bit 0 (the delay bit) and input bits 32..63 have no effect on the output.
- R7: A word-select transition after any number of input bits restarts the output slot at position 0 on the new channel. A left slot of 16 input bits yields exactly 8 output positions, carrying position 0 and the 7 leading sample bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock, 256 times the sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_in | input | 1 | Input bit clock, 128 times the sample rate |
| ws_in | input | 1 | Input word-select, 0 = left, 1 = right |
| sd_in | input | 1 | Input serial data, changes on falling bclk_in |
| bclk_out | output | 1 | Regenerated bit clock, 64 times the sample rate |
| ws_out | output | 1 | Output word-select, 0 = left, 1 = right |
| sd_out | output | 1 | Output serial data, changes while bclk_out is low |

## Verification
The hardest case to reach from the ports is a word-select transition in the middle of a slot. It cuts the emitter off part way through a bit period and must restart it cleanly on the other channel. The bench's slot driver takes a bit count, so one left slot ends after 16 input bits, and the bench checks the exact count and content of the truncated output slot and the full slot that follows. The same driver can fill the delay bit and the discarded tail of each input slot with ones, which shows that none of them leak into the output.

// File: rtl/i2s_slot_halver_pkg.sv
`timescale 1ns/1ps
package i2s_slot_halver_pkg;

    // Input side: waiting for a first slot, storing bits, discarding the tail
    typedef enum logic [1:0] {
        CAP_WAIT = 2'd0,
        CAP_FILL = 2'd1,
        CAP_DROP = 2'd2
    } cap_state_t;

    // Output side: quiet before the first slot, then alternating clock halves
    typedef enum logic [1:0] {
        EMIT_IDLE = 2'd0,
        EMIT_LOW  = 2'd1,
        EMIT_HIGH = 2'd2
    } emit_state_t;

endpackage

// File: rtl/i2s_slot_halver_sync.sv
`timescale 1ns/1ps
module i2s_slot_halver_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/i2s_slot_halver_capture.sv
`timescale 1ns/1ps
module i2s_slot_halver_capture
    import i2s_slot_halver_pkg::*;
#(
    parameter int KEEP = 31
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bclk_s,
    input  logic            ws_s,
    input  logic            sd_s,
    output logic            slot_start,
    output logic            slot_ws,
    output logic [KEEP-1:0] held
);

    localparam int IDX_W = $clog2(KEEP);

    cap_state_t       state, nxt_state;
    logic             bclk_d;
    logic             ws_ref;
    logic             ref_ok;
    logic [IDX_W-1:0] idx;
    logic             rise;
    logic             last_slot_bit;

    assign rise          = bclk_s & ~bclk_d;
    assign slot_start    = rise & ref_ok & (ws_s ^ ws_ref);
    assign slot_ws       = ws_s;
    assign last_slot_bit = (idx == IDX_W'(KEEP - 1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CAP_WAIT;
        else        state <= nxt_state;
    end

    // Transitions: a word-select edge always reopens FILL
    always_comb begin
        nxt_state = state;
        unique case (state)
            CAP_WAIT: if (slot_start) nxt_state = CAP_FILL;
            CAP_FILL: begin
                if (slot_start)                 nxt_state = CAP_FILL;
                else if (rise && last_slot_bit) nxt_state = CAP_DROP;
            end
            CAP_DROP: if (slot_start) nxt_state = CAP_FILL;
            default:  nxt_state = CAP_WAIT;
        endcase
    end

    // Edge reference, write index and holding buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_d <= 1'b0;
            ws_ref <= 1'b0;
            ref_ok <= 1'b0;
            idx    <= '0;
            held   <= '0;
        end else begin
            bclk_d <= bclk_s;
            if (rise) begin
                ws_ref <= ws_s;
                ref_ok <= 1'b1;
            end
            if (slot_start) begin
                held <= '0;
                idx  <= '0;
            end else if (rise && state == CAP_FILL) begin
                held[idx] <= sd_s;
                idx       <= idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/i2s_slot_halver_emit.sv
`timescale 1ns/1ps
module i2s_slot_halver_emit
    import i2s_slot_halver_pkg::*;
#(
    parameter int SLOT_OUT = 32,
    parameter int OUT_DIV  = 4,
    parameter int KEEP     = 31
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            slot_start,
    input  logic            slot_ws,
    input  logic [KEEP-1:0] held,
    output logic            bclk_out,
    output logic            ws_out,
    output logic            sd_out
);

    localparam int BIT_W = $clog2(SLOT_OUT + 1);
    localparam int PH_W  = $clog2(OUT_DIV);
    localparam int HALF  = OUT_DIV / 2;
    localparam int IDX_W = $clog2(KEEP);

    emit_state_t      state, nxt_state;
    logic [PH_W-1:0]  ph, nxt_ph;
    logic [BIT_W-1:0] pos, nxt_pos;
    logic             launch;
    logic [BIT_W-1:0] rd;
    logic             pick;

    // State register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= EMIT_IDLE;
            ph    <= '0;
            pos   <= '0;
        end else begin
            state <= nxt_state;
            ph    <= nxt_ph;
            pos   <= nxt_pos;
        end
    end

    always_comb begin
        nxt_state = state;
        nxt_ph    = ph;
        nxt_pos   = pos;
        launch    = 1'b0;
        if (slot_start) begin
            nxt_state = EMIT_LOW;
            nxt_ph    = '0;
            nxt_pos   = '0;
            launch    = 1'b1;
        end else begin
            unique case (state)
                EMIT_IDLE: nxt_state = EMIT_IDLE;
                EMIT_LOW: begin
                    nxt_ph = ph + 1'b1;
                    if (ph == PH_W'(HALF - 1)) nxt_state = EMIT_HIGH;
                end
                EMIT_HIGH: begin
                    nxt_ph = ph + 1'b1;
                    if (ph == PH_W'(OUT_DIV - 1)) begin
                        nxt_state = EMIT_LOW;
                        nxt_ph    = '0;
                        launch    = 1'b1;
                        if (pos != BIT_W'(SLOT_OUT)) nxt_pos = pos + 1'b1;
                    end
                end
                default: nxt_state = EMIT_IDLE;
            endcase
        end
    end

    // Data bit for the position being launched
    always_comb begin
        rd   = nxt_pos - 1'b1;
        pick = 1'b0;
        if (nxt_pos != '0 && nxt_pos <= BIT_W'(KEEP))
            pick = held[rd[IDX_W-1:0]];
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_out <= 1'b0;
            ws_out   <= 1'b0;
            sd_out   <= 1'b0;
        end else begin
            bclk_out <= (nxt_state == EMIT_HIGH);
            if (slot_start) ws_out <= slot_ws;
            if (launch)     sd_out <= pick;
        end
    end

endmodule

// File: rtl/i2s_slot_halver.sv
`timescale 1ns/1ps
module i2s_slot_halver #(
    parameter int SLOT_IN     = 64,
    parameter int OUT_DIV     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic mclk,
    input  logic rst_n,
    input  logic bclk_in,
    input  logic ws_in,
    input  logic sd_in,
    output logic bclk_out,
    output logic ws_out,
    output logic sd_out
);

    localparam int SLOT_OUT = SLOT_IN / 2;
    localparam int KEEP     = SLOT_OUT - 1;

    logic [2:0]      raw_bus, sync_bus;
    logic            slot_start;
    logic            slot_ws;
    logic [KEEP-1:0] held;

    assign raw_bus = {bclk_in, ws_in, sd_in};

    i2s_slot_halver_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (mclk),
        .rst_n (rst_n),
        .d     (raw_bus),
        .q     (sync_bus)
    );

    i2s_slot_halver_capture #(
        .KEEP (KEEP)
    ) u_capture (
        .clk        (mclk),
        .rst_n      (rst_n),
        .bclk_s     (sync_bus[2]),
        .ws_s       (sync_bus[1]),
        .sd_s       (sync_bus[0]),
        .slot_start (slot_start),
        .slot_ws    (slot_ws),
        .held       (held)
    );

    i2s_slot_halver_emit #(
        .SLOT_OUT (SLOT_OUT),
        .OUT_DIV  (OUT_DIV),
        .KEEP     (KEEP)
    ) u_emit (
        .clk        (mclk),
        .rst_n      (rst_n),
        .slot_start (slot_start),
        .slot_ws    (slot_ws),
        .held       (held),
        .bclk_out   (bclk_out),
        .ws_out     (ws_out),
        .sd_out     (sd_out)
    );

endmodule

// File: rtl/i2s_slot_halver_chk.sv
`timescale 1ns/1ps
module i2s_slot_halver_chk (
    input logic clk,
    input logic rst_n,
    input logic bclk_out,
    input logic ws_out,
    input logic sd_out
);

    logic       started;
    logic       ob_d;
    logic [6:0] rises;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started <= 1'b0;
            ob_d    <= 1'b0;
            rises   <= '0;
        end else begin
            ob_d <= bclk_out;
            if (bclk_out) started <= 1'b1;
            if (ws_out != $past(ws_out))     rises <= '0;
            else if (bclk_out && !ob_d && rises != 7'h7f) rises <= rises + 1'b1;
        end
    end

    // R1: no data before the regenerated clock has ever run
    assert_quiet_before_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !started |-> !sd_out);

    // R2: every rise follows at least two low cycles
    assert_low_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bclk_out) |-> !$past(bclk_out, 2));

    // R3: a slot never carries more than 32 output bit periods
    assert_slot_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ws_out) |-> (rises <= 7'd32));

    // R4: word-select moves only while the clock is low
    assert_ws_on_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ws_out) |-> !bclk_out);

    // R4: data moves only while the clock is low
    assert_sd_on_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sd_out) |-> !bclk_out);

    // R6: position 0 of every slot carries a zero
    assert_pos0_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ws_out) |-> !sd_out);

endmodule

bind i2s_slot_halver i2s_slot_halver_chk u_chk (
    .clk      (mclk),
    .rst_n    (rst_n),
    .bclk_out (bclk_out),
    .ws_out   (ws_out),
    .sd_out   (sd_out)
);

// File: tb/i2s_slot_halver_test.sv
`timescale 1ns/1ps
module i2s_slot_halver_test;

    logic mclk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk_in = 1'b0;
    logic ws_in = 1'b1;
    logic sd_in = 1'b0;
    logic bclk_out, ws_out, sd_out;

    always #2.5 mclk = ~mclk;

    i2s_slot_halver uut (
        .mclk     (mclk),
        .rst_n    (rst_n),
        .bclk_in  (bclk_in),
        .ws_in    (ws_in),
        .sd_in    (sd_in),
        .bclk_out (bclk_out),
        .ws_out   (ws_out),
        .sd_out   (sd_out)
    );

    // {junk in delay bit and tail, left sample, right sample}
    localparam logic [48:0] VEC [6] = '{
        {1'b0, 24'hA5A5A5, 24'h5A5A5A},
        {1'b1, 24'h800000, 24'h7FFFFF},
        {1'b0, 24'hFFFFFF, 24'h000001},
        {1'b1, 24'h3FFFC0, 24'hABCD40},
        {1'b0, 24'h000000, 24'hFFFFFF},
        {1'b1, 24'h123456, 24'hFEDCBA}
    };

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // expected slots
    int          n_exp = 0;
    logic        exp_ws   [32];
    logic [23:0] exp_val  [32];
    int          exp_len  [32];
    bit          exp_short[32];

    // monitor records
    int          n_rec = 0;
    logic        rec_ws  [32];
    logic [23:0] rec_val [32];
    int          rec_len [32];
    logic        rec_p0  [32];
    logic        rec_tail[32];

    bit          mon_on = 0;
    logic        mon_ws;
    logic [23:0] mon_val;
    int          mon_len;
    logic        mon_p0, mon_tail;
    logic        ob_prev = 1'b0;
    int          gap = 0;
    int          gap_bad = 0;
    int          hold_bad = 0;
    int          total_rises = 0;
    logic        held_sd, held_ws;

    task automatic check(input string tag, input bit ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_slot(input logic ch, input logic [23:0] v, input int len, input bit sh);
        exp_ws[n_exp]    = ch;
        exp_val[n_exp]   = v;
        exp_len[n_exp]   = len;
        exp_short[n_exp] = sh;
        n_exp++;
    endtask

    task automatic drive_slot(input logic ch, input logic [23:0] smp, input int nbits, input logic junk);
        for (int i = 0; i < nbits; i++) begin
            @(negedge mclk);
            bclk_in = 1'b0;
            ws_in   = ch;
            if (i >= 1 && i <= 24)     sd_in = smp[24-i];
            else if (i == 0 || i >= 32) sd_in = junk;
            else                        sd_in = 1'b0;
            @(negedge mclk);
            bclk_in = 1'b1;
        end
    endtask

    // Output monitor, sampled away from the active edge
    always @(negedge mclk) begin
        if (rst_n) begin
            gap++;
            if (bclk_out && ob_prev && (sd_out !== held_sd || ws_out !== held_ws)) hold_bad++;
            if (bclk_out && !ob_prev) begin
                total_rises++;
                held_sd = sd_out;
                held_ws = ws_out;
                if (!mon_on || ws_out !== mon_ws) begin
                    if (mon_on && n_rec < 32) begin
                        rec_ws[n_rec]   = mon_ws;
                        rec_val[n_rec]  = mon_val;
                        rec_len[n_rec]  = mon_len;
                        rec_p0[n_rec]   = mon_p0;
                        rec_tail[n_rec] = mon_tail;
                        n_rec++;
                    end
                    mon_on   = 1;
                    mon_ws   = ws_out;
                    mon_len  = 0;
                    mon_val  = '0;
                    mon_p0   = 1'b0;
                    mon_tail = 1'b0;
                end else if (gap != 4) begin
                    gap_bad++;
                end
                if (mon_len == 0)      mon_p0 = sd_out;
                else if (mon_len <= 24) mon_val = {mon_val[22:0], sd_out};
                else                   mon_tail = mon_tail | sd_out;
                mon_len++;
                gap = 0;
            end
            ob_prev = bclk_out;
        end
    end

    initial begin
        repeat (100000) @(posedge mclk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (8) @(negedge mclk);
        rst_n = 1'b1;
        @(negedge mclk);
        // R1: reset state
        check("R1 reset bclk_out", bclk_out == 1'b0, bclk_out, 0);
        check("R1 reset ws_out",   ws_out   == 1'b0, ws_out,   0);
        check("R1 reset sd_out",   sd_out   == 1'b0, sd_out,   0);

        // Reference slot: word-select held high, no transition yet
        drive_slot(1'b1, 24'hFFFFFF, 64, 1'b1);
        check("R1 no output before first ws edge", total_rises == 0, total_rises, 0);
        check("R1 sd_out quiet before first ws edge", sd_out == 1'b0, sd_out, 0);

        // Table walk
        for (int v = 0; v < 6; v++) begin
            expect_slot(1'b0, VEC[v][47:24], 32, 0);
            expect_slot(1'b1, VEC[v][23:0],  32, 0);
            drive_slot(1'b0, VEC[v][47:24], 64, VEC[v][48]);
            drive_slot(1'b1, VEC[v][23:0],  64, VEC[v][48]);
        end

        // R7: truncated left slot, then full right slot
        expect_slot(1'b0, 24'h123456, 8, 1);
        expect_slot(1'b1, 24'hC0FFEE, 32, 0);
        expect_slot(1'b0, 24'h000000, 32, 0);
        drive_slot(1'b0, 24'h123456, 16, 1'b0);
        drive_slot(1'b1, 24'hC0FFEE, 64, 1'b1);
        drive_slot(1'b0, 24'h000000, 64, 1'b0);
        drive_slot(1'b1, 24'h000000, 4,  1'b0);
        repeat (30) @(negedge mclk);

        check("R3 slot count", n_rec == n_exp, n_rec, n_exp);
        for (int k = 0; k < n_exp && k < n_rec; k++) begin
            check("R5 channel", rec_ws[k] == exp_ws[k], rec_ws[k], exp_ws[k]);
            check("R6 position 0 zero", rec_p0[k] == 1'b0, rec_p0[k], 0);
            if (exp_short[k]) begin
                check("R7 short slot length", rec_len[k] == exp_len[k], rec_len[k], exp_len[k]);
                check("R7 short slot leading bits", rec_val[k][6:0] == exp_val[k][23:17],
                      rec_val[k][6:0], exp_val[k][23:17]);
            end else begin
                check("R3 slot length 32", rec_len[k] == exp_len[k], rec_len[k], exp_len[k]);
                check("R5 sample value", rec_val[k] == exp_val[k], rec_val[k], exp_val[k]);
                check("R6 tail positions zero", rec_tail[k] == 1'b0, rec_tail[k], 0);
            end
        end
        check("R2 rise spacing 4 cycles", gap_bad == 0, gap_bad, 0);
        check("R4 stable during high phase", hold_bad == 0, hold_bad, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule